// File: doc/BRIEF.md
# Dual-View Processor Status Flag Unit

This block holds the processor status flags and shows them through two byte-wide register views: a legacy status byte and an extended status byte. Carry, auxiliary carry, the two register-bank select bits and overflow each exist once. Either view reads and writes the same stored bit, so a write through one view is seen at once in the other. The legacy view also holds two general user bits. The extended view also holds a negative flag and a zero flag.

Each cycle the block can also take the result of one ALU operation. The inputs are an operation class, an operand width, the result, the carry-out, the auxiliary carry, the overflow, a divide-by-zero indication and the last bit shifted out. From these the block works out which flags the class changes and loads their new values. The carry, overflow, negative, zero and bank-select bits are also driven as separate outputs for use by the rest of the core.

Top module: `flag_unit`

## Requirements
- R1: After reset every stored bit is zero, so both views read 00h and every flag output is 0.
- R2: A legacy write stores bit7=CY, bit6=AC, bit5=F0, bit4=RS1, bit3=RS0, bit2=OV and bit1=UD. Legacy bit0 always reads 0. The legacy view then reads back the written byte with bit0 cleared. The extended view shows the new CY, AC, RS1, RS0 and OV in the same bit positions.
- R3: An extended write stores bit7=CY, bit6=AC, bit5=N, bit4=RS1, bit3=RS0, bit2=OV and bit1=Z. Extended bit0 always reads 0. F0 and UD are left unchanged, and the legacy view shows the new shared bits.
- R4: When both views are written in the same cycle, the shared bits take the extended write data. F0 and UD come from the legacy data, and N and Z come from the extended data.
- R5: In any cycle with a software write, the ALU update is ignored entirely.
- R6: Operation class 1 (add, add with carry, subtract, compare) loads CY from the carry-out, OV from the overflow input, and N and Z from the result.
- R7: AC is loaded from the auxiliary carry input only for class 1 at byte width (width code 0). At word width (code 1) and dword width (code 2 or 3), AC is left unchanged.
- R8: N is the result bit 7, 15 or 31 for width codes 0, 1 or 2/3. Z is 1 when result bits [7:0], [15:0] or [31:0] respectively are all zero. Result bits above the width are ignored.
- R9: Class 2 (increment/decrement) and class 6 (logical, complement, rotate, swap) load only N and Z.
- R10: Class 3 (multiply) clears CY, loads OV from the overflow input, and loads N and Z. Class 4 (divide) does the same when the divisor is nonzero. A divide by zero sets OV, clears CY and leaves N, Z and AC unchanged.
- R11: Class 5 (decimal adjust) loads CY from the carry-out, and N and Z from the result. AC and OV are left unchanged.
- R12: Class 7 (shifts and rotates through carry) loads CY from the last-bit-shifted-out input, and N and Z from the result.
- R13: Class 0, or a cycle with the ALU valid input low, leaves every flag unchanged.
- R14: The bank-select output is {RS1,RS0}, and each flag output equals its stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| legWrEn | input | 1 | Write strobe for the legacy view |
| legWrData | input | 8 | Legacy write data |
| extWrEn | input | 1 | Write strobe for the extended view |
| extWrData | input | 8 | Extended write data |
| legRdData | output | 8 | Legacy view read data |
| extRdData | output | 8 | Extended view read data |
| aluValid | input | 1 | An ALU result is present this cycle |
| aluOp | input | 3 | Operation class code |
| aluWidth | input | 2 | Operand width: 0 byte, 1 word, 2/3 dword |
| aluResult | input | 32 | ALU result |
| aluCarry | input | 1 | Carry-out |
| aluAuxCarry | input | 1 | Carry out of bit 3 |
| aluOvf | input | 1 | Overflow |
| aluDivZero | input | 1 | Divisor was zero |
| aluShiftOut | input | 1 | Last bit shifted out |
| flagCy | output | 1 | Carry flag |
| flagAc | output | 1 | Auxiliary carry flag |
| flagOv | output | 1 | Overflow flag |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| bankSel | output | 2 | Register bank select {RS1,RS0} |

## Verification
Two situations are hard to reach from the ports. The first is a software write that lands in the same cycle as a valid ALU update. The second is both views written in one cycle, each carrying different data. The random stimulus draws the two write strobes and the ALU valid input independently in every cycle, so these collisions happen often. Directed steps then force each one with conflicting values. The Z flag rarely comes out as 1 with random results, so the stimulus often masks the low bits of the result to zero and leaves the upper bits random. This tests zero detection at each width against the higher bits the block must ignore.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int OP_W = 3;
  localparam int WID_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NONE   = 3'd0,
    OP_ARITH  = 3'd1,
    OP_INCDEC = 3'd2,
    OP_MUL    = 3'd3,
    OP_DIV    = 3'd4,
    OP_DECADJ = 3'd5,
    OP_LOGIC  = 3'd6,
    OP_SHIFT  = 3'd7
  } opClass_e;

  typedef enum logic [1:0] {
    CY_FROM_CARRY = 2'd0,
    CY_FROM_SHIFT = 2'd1,
    CY_FORCE_ZERO = 2'd2
  } cySrc_e;

  typedef struct packed {
    logic   swLeg;
    logic   swExt;
    logic   updCy;
    cySrc_e cySrc;
    logic   updAc;
    logic   updOv;
    logic   ovSet;
    logic   updNz;
  } flagStrobe_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic             legWrEn,
  input  logic             extWrEn,
  input  logic             aluValid,
  input  logic [OP_W-1:0]  aluOp,
  input  logic [WID_W-1:0] aluWidth,
  input  logic             aluDivZero,
  output flagStrobe_t      strobe
);
  logic aluLive;
  logic byteWidth;

  assign aluLive   = aluValid && !legWrEn && !extWrEn;
  assign byteWidth = (aluWidth == '0);

  always_comb begin
    strobe       = '0;
    strobe.swLeg = legWrEn;
    strobe.swExt = extWrEn;
    strobe.cySrc = CY_FROM_CARRY;
    if (aluLive) begin
      unique case (opClass_e'(aluOp))
        OP_ARITH: begin
          strobe.updCy = 1'b1;
          strobe.updAc = byteWidth;
          strobe.updOv = 1'b1;
          strobe.updNz = 1'b1;
        end
        OP_INCDEC, OP_LOGIC: begin
          strobe.updNz = 1'b1;
        end
        OP_MUL: begin
          strobe.updCy = 1'b1;
          strobe.cySrc = CY_FORCE_ZERO;
          strobe.updOv = 1'b1;
          strobe.updNz = 1'b1;
        end
        OP_DIV: begin
          strobe.updCy = 1'b1;
          strobe.cySrc = CY_FORCE_ZERO;
          strobe.updOv = 1'b1;
          strobe.ovSet = aluDivZero;
          strobe.updNz = !aluDivZero;
        end
        OP_DECADJ: begin
          strobe.updCy = 1'b1;
          strobe.updNz = 1'b1;
        end
        OP_SHIFT: begin
          strobe.updCy = 1'b1;
          strobe.cySrc = CY_FROM_SHIFT;
          strobe.updNz = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flag_dp.sv
module flag_dp
  import flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strobe,
  input  logic [7:0]        legWrData,
  input  logic [7:0]        extWrData,
  input  logic [WID_W-1:0]  aluWidth,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              aluAuxCarry,
  input  logic              aluOvf,
  input  logic              aluShiftOut,
  output logic [7:0]        legRdData,
  output logic [7:0]        extRdData,
  output logic              flagCy,
  output logic              flagAc,
  output logic              flagOv,
  output logic              flagN,
  output logic              flagZ,
  output logic [1:0]        bankSel
);
  localparam int BYTE_W = 8;
  localparam int WORD_W = (DATA_W < 16) ? DATA_W : 16;

  logic cyQ, acQ, f0Q, rs1Q, rs0Q, ovQ, udQ, nQ, zQ;
  logic resN, resZ, cyNext, ovNext;

  always_comb begin
    unique case (aluWidth)
      2'd0: begin
        resN = aluResult[BYTE_W-1];
        resZ = (aluResult[BYTE_W-1:0] == '0);
      end
      2'd1: begin
        resN = aluResult[WORD_W-1];
        resZ = (aluResult[WORD_W-1:0] == '0);
      end
      default: begin
        resN = aluResult[DATA_W-1];
        resZ = (aluResult == '0);
      end
    endcase
  end

  always_comb begin
    unique case (strobe.cySrc)
      CY_FROM_SHIFT: cyNext = aluShiftOut;
      CY_FORCE_ZERO: cyNext = 1'b0;
      default:       cyNext = aluCarry;
    endcase
    ovNext = strobe.ovSet ? 1'b1 : aluOvf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {cyQ, acQ, f0Q, rs1Q, rs0Q, ovQ, udQ, nQ, zQ} <= '0;
    end else if (strobe.swLeg || strobe.swExt) begin
      if (strobe.swLeg) begin
        {cyQ, acQ, f0Q, rs1Q, rs0Q, ovQ, udQ} <= legWrData[7:1];
      end
      if (strobe.swExt) begin
        {cyQ, acQ, nQ, rs1Q, rs0Q, ovQ, zQ} <= extWrData[7:1];
      end
    end else begin
      if (strobe.updCy) cyQ <= cyNext;
      if (strobe.updAc) acQ <= aluAuxCarry;
      if (strobe.updOv) ovQ <= ovNext;
      if (strobe.updNz) begin
        nQ <= resN;
        zQ <= resZ;
      end
    end
  end

  assign legRdData = {cyQ, acQ, f0Q, rs1Q, rs0Q, ovQ, udQ, 1'b0};
  assign extRdData = {cyQ, acQ, nQ, rs1Q, rs0Q, ovQ, zQ, 1'b0};
  assign flagCy    = cyQ;
  assign flagAc    = acQ;
  assign flagOv    = ovQ;
  assign flagN     = nQ;
  assign flagZ     = zQ;
  assign bankSel   = {rs1Q, rs0Q};

  // R2
  leg_write_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.swLeg && !strobe.swExt) |=> (legRdData == {$past(legWrData[7:1]), 1'b0}));

  // R3
  ext_write_keeps_user_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.swExt && !strobe.swLeg) |=> ($stable(f0Q) && $stable(udQ)));

  // R7
  ac_wide_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.swLeg && !strobe.swExt && aluWidth != 2'd0) |=> $stable(acQ));

  // R10
  div_zero_ov_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ovSet && !strobe.swLeg && !strobe.swExt) |=> (ovQ && !cyQ));

  // R12
  shift_cy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.updCy && strobe.cySrc == CY_FROM_SHIFT) |=> (cyQ == $past(aluShiftOut)));

  // R5
  sw_over_alu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.swExt) |=> (extRdData == {$past(extWrData[7:1]), 1'b0}));
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              legWrEn,
  input  logic [7:0]        legWrData,
  input  logic              extWrEn,
  input  logic [7:0]        extWrData,
  output logic [7:0]        legRdData,
  output logic [7:0]        extRdData,
  input  logic              aluValid,
  input  logic [2:0]        aluOp,
  input  logic [1:0]        aluWidth,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              aluAuxCarry,
  input  logic              aluOvf,
  input  logic              aluDivZero,
  input  logic              aluShiftOut,
  output logic              flagCy,
  output logic              flagAc,
  output logic              flagOv,
  output logic              flagN,
  output logic              flagZ,
  output logic [1:0]        bankSel
);
  flagStrobe_t strobe;

  flag_ctrl u_ctrl (
    .legWrEn    (legWrEn),
    .extWrEn    (extWrEn),
    .aluValid   (aluValid),
    .aluOp      (aluOp),
    .aluWidth   (aluWidth),
    .aluDivZero (aluDivZero),
    .strobe     (strobe)
  );

  flag_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .legWrData   (legWrData),
    .extWrData   (extWrData),
    .aluWidth    (aluWidth),
    .aluResult   (aluResult),
    .aluCarry    (aluCarry),
    .aluAuxCarry (aluAuxCarry),
    .aluOvf      (aluOvf),
    .aluShiftOut (aluShiftOut),
    .legRdData   (legRdData),
    .extRdData   (extRdData),
    .flagCy      (flagCy),
    .flagAc      (flagAc),
    .flagOv      (flagOv),
    .flagN       (flagN),
    .flagZ       (flagZ),
    .bankSel     (bankSel)
  );
endmodule

// File: tb/flag_unit_bench.sv
module flag_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic legWrEn = 0, extWrEn = 0, aluValid = 0;
  logic [7:0] legWrData = 0, extWrData = 0;
  logic [2:0] aluOp = 0;
  logic [1:0] aluWidth = 0;
  logic [31:0] aluResult = 0;
  logic aluCarry = 0, aluAuxCarry = 0, aluOvf = 0, aluDivZero = 0, aluShiftOut = 0;
  logic [7:0] legRdData, extRdData;
  logic flagCy, flagAc, flagOv, flagN, flagZ;
  logic [1:0] bankSel;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  // model state
  logic mCy, mAc, mF0, mRs1, mRs0, mOv, mUd, mN, mZ;

  always #5 clk = ~clk;

  flag_unit u_flag_unit (.*);

  function automatic logic [7:0] expLeg();
    return {mCy, mAc, mF0, mRs1, mRs0, mOv, mUd, 1'b0};
  endfunction
  function automatic logic [7:0] expExt();
    return {mCy, mAc, mN, mRs1, mRs0, mOv, mZ, 1'b0};
  endfunction
  function automatic logic calcN(logic [1:0] w, logic [31:0] r);
    if (w == 2'd0) return r[7];
    if (w == 2'd1) return r[15];
    return r[31];
  endfunction
  function automatic logic calcZ(logic [1:0] w, logic [31:0] r);
    if (w == 2'd0) return r[7:0] == 8'h00;
    if (w == 2'd1) return r[15:0] == 16'h0000;
    return r == 32'h0;
  endfunction

  task automatic modelStep();
    if (legWrEn || extWrEn) begin
      if (legWrEn) {mCy, mAc, mF0, mRs1, mRs0, mOv, mUd} = legWrData[7:1];
      if (extWrEn) {mCy, mAc, mN, mRs1, mRs0, mOv, mZ} = extWrData[7:1];
    end else if (aluValid) begin
      case (aluOp)
        3'd1: begin
          mCy = aluCarry; mOv = aluOvf;
          if (aluWidth == 2'd0) mAc = aluAuxCarry;
          mN = calcN(aluWidth, aluResult); mZ = calcZ(aluWidth, aluResult);
        end
        3'd2, 3'd6: begin
          mN = calcN(aluWidth, aluResult); mZ = calcZ(aluWidth, aluResult);
        end
        3'd3: begin
          mCy = 0; mOv = aluOvf;
          mN = calcN(aluWidth, aluResult); mZ = calcZ(aluWidth, aluResult);
        end
        3'd4: begin
          mCy = 0;
          if (aluDivZero) mOv = 1;
          else begin
            mOv = aluOvf;
            mN = calcN(aluWidth, aluResult); mZ = calcZ(aluWidth, aluResult);
          end
        end
        3'd5: begin
          mCy = aluCarry;
          mN = calcN(aluWidth, aluResult); mZ = calcZ(aluWidth, aluResult);
        end
        3'd7: begin
          mCy = aluShiftOut;
          mN = calcN(aluWidth, aluResult); mZ = calcZ(aluWidth, aluResult);
        end
        default: ;
      endcase
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check({tag, " legacy view"}, {24'h0, legRdData}, {24'h0, expLeg()});
    check({tag, " extended view"}, {24'h0, extRdData}, {24'h0, expExt()});
    check({"R14 outputs / ", tag},
          {25'h0, flagCy, flagAc, flagOv, flagN, flagZ, bankSel},
          {25'h0, mCy, mAc, mOv, mN, mZ, mRs1, mRs0});
  endtask

  function automatic string opTag(logic [2:0] op, logic lw, logic ew, logic v);
    if (lw && ew) return "R4";
    if ((lw || ew) && v) return "R5";
    if (lw) return "R2";
    if (ew) return "R3";
    if (!v) return "R13";
    case (op)
      3'd1: return "R6 R7 R8";
      3'd2, 3'd6: return "R9";
      3'd3, 3'd4: return "R10";
      3'd5: return "R11";
      3'd7: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic step();
    string tag;
    tag = opTag(aluOp, legWrEn, extWrEn, aluValid);
    modelStep();
    @(posedge clk);
    #1;
    checkAll(tag);
    @(negedge clk);
    legWrEn = 0; extWrEn = 0; aluValid = 0;
  endtask

  task automatic aluDo(logic [2:0] op, logic [1:0] w, logic [31:0] r,
                       logic c, logic a, logic o, logic dz, logic s);
    aluValid = 1; aluOp = op; aluWidth = w; aluResult = r;
    aluCarry = c; aluAuxCarry = a; aluOvf = o; aluDivZero = dz; aluShiftOut = s;
    step();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    {mCy, mAc, mF0, mRs1, mRs0, mOv, mUd, mN, mZ} = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1
    checkAll("R1 reset");

    // R2 legacy write, bit0 forced to read zero
    @(negedge clk);
    legWrEn = 1; legWrData = 8'hFF; step();
    // R3 extended write leaves F0/UD
    extWrEn = 1; extWrData = 8'h00; step();
    // R4 both views same cycle with conflicting data
    legWrEn = 1; legWrData = 8'h5A; extWrEn = 1; extWrData = 8'hA7; step();
    // R5 write collides with ALU arithmetic
    legWrEn = 1; legWrData = 8'h00;
    aluDo(3'd1, 2'd0, 32'h0, 1, 1, 1, 0, 1);
    // R7 AC set then wide add with aux carry low
    aluDo(3'd1, 2'd0, 32'h80, 1, 1, 0, 0, 0);
    aluDo(3'd1, 2'd1, 32'hFFFF_0000, 0, 0, 1, 0, 0);
    aluDo(3'd1, 2'd2, 32'h8000_0000, 0, 0, 0, 0, 0);
    // R8 zero in low bits with upper bits set
    aluDo(3'd6, 2'd0, 32'hABCD_EF00, 0, 0, 0, 0, 0);
    aluDo(3'd2, 2'd1, 32'h1234_8000, 0, 0, 0, 0, 0);
    // R10 divide by zero
    aluDo(3'd1, 2'd0, 32'h1, 1, 0, 0, 0, 0);
    aluDo(3'd4, 2'd0, 32'h0, 1, 1, 0, 1, 1);
    aluDo(3'd3, 2'd0, 32'h0, 1, 1, 1, 0, 1);
    // R12 shift-out into CY
    aluDo(3'd7, 2'd3, 32'h0, 0, 0, 0, 0, 1);
    // R11 decimal adjust
    aluDo(3'd5, 2'd0, 32'h99, 1, 0, 1, 0, 0);
    // R13 class 0 and invalid cycle
    aluDo(3'd0, 2'd0, 32'h0, 0, 1, 1, 0, 0);
    aluValid = 0; aluOp = 3'd1; step();

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] rnd;
      rnd = $urandom;
      legWrEn = ($urandom % 6) == 0;
      extWrEn = ($urandom % 6) == 0;
      legWrData = 8'($urandom);
      extWrData = 8'($urandom);
      aluValid = ($urandom % 5) != 0;
      aluOp = 3'($urandom);
      aluWidth = 2'($urandom);
      case ($urandom % 4)
        0: rnd = rnd & 32'hFFFF_FF00;
        1: rnd = rnd & 32'hFFFF_0000;
        2: rnd = 32'h0;
        default: ;
      endcase
      aluResult = rnd;
      {aluCarry, aluAuxCarry, aluOvf, aluShiftOut} = 4'($urandom);
      aluDivZero = ($urandom % 4) == 0;
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule